// File: doc/BRIEF.md
# Multi-Port PHY Reset Sequencer

This block drives a software-free reset of several Ethernet PHY ports that sit behind a management register path. A client pulses `start`. The block takes a snapshot of the number of ports, the set of ports whose completion it waits for, and the PHY address that belongs to each port slot. It then puts every port into reset with a read-modify-write of the control register. The reset flag is bit 15 of register 0.

After the reset writes, the block polls. In each pass it reads register 0 of every port and records each port whose reset flag has cleared by itself. Passes are separated by a fixed gap measured in millisecond ticks. Polling stops once the completion mask equals the requested mask, or once a timeout has run out. Any port that never completed gets its reset flag cleared by hand. After one more gap, the block reports the completion mask together with a one-cycle done pulse.

Register transactions leave through a simple request port that carries a write flag, a 5-bit PHY address, a 5-bit register number and 16 bits of data. The responder ends each transaction with a one-cycle `rsp_done`. The serial management framing is handled by whatever answers that port.

Top module: `port_reset_seq`

## Requirements
- R1: After reset, `busy`, `req_valid` and `done_pulse` are 0 and `done_mask` is all zeros.
- R2: `start` is accepted only while `busy` is 0, and the port count, requested mask and address table are sampled at that moment. A `start` during a run changes neither the run nor its result, and no request is issued while idle.
- R3: Every request addresses register 0. Once `req_valid` is raised, its fields stay stable until `rsp_done` arrives. `req_valid` drops in the cycle after `rsp_done`, so each `rsp_done` ends exactly one transaction.
- R4: For each port below the count, in slot order, register 0 is read. The value read is then written back with bit 15 set and all other bits unchanged.
- R5: Each polling pass reads register 0 of every port below the count, including ports that have already completed. A port's completion bit is set when bit 15 reads back as 0, and it then stays set for the rest of the run.
- R6: Polling ends after the first pass in which the completion mask equals the requested mask. It also ends after the first pass that finishes with at least TIMEOUT_MS ticks elapsed since polling began.
- R7: Consecutive polling passes are separated by a wait of GAP_MS ticks of `tick_ms`.
- R8: For each port below the count whose completion bit is 0 after polling, register 0 is read and written back with bit 15 cleared and all other bits unchanged. Completed ports receive no write after the reset write.
- R9: After recovery, the block waits GAP_MS ticks. It then raises `done_pulse` for exactly one cycle, with `done_mask` carrying the completion mask (bit i for port slot i). `done_mask` keeps that value until the next report.
- R10: Port slots at or above the count are never accessed, and their `done_mask` bits are 0.
- R11: Requests for port slot i carry the PHY address held in `addr_table[5*i+4:5*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| start | input | 1 | Begin a reset run (ignored while busy) |
| port_count | input | $clog2(MAX_PORTS+1) | Number of port slots in use |
| port_mask | input | MAX_PORTS | Slots whose completion ends polling early |
| addr_table | input | 5*MAX_PORTS | PHY address of each slot, slot i at bits 5i+4..5i |
| req_valid | output | 1 | Register transaction pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_phy | output | 5 | PHY address of the transaction |
| req_reg | output | 5 | Register number (always 0) |
| req_wdata | output | 16 | Write data |
| rsp_done | input | 1 | Transaction finished (one cycle) |
| rsp_rdata | input | 16 | Read data, valid with `rsp_done` |
| busy | output | 1 | A run is in progress |
| done_pulse | output | 1 | One-cycle end-of-run strobe |
| done_mask | output | MAX_PORTS | Per-slot completion result |

## Verification
The hardest situation to reach from the ports is a run where some ports finish and others stay in reset for good. Only that case exercises the timeout exit and the selective recovery writes. The bench uses a behavioural PHY responder in which each address can clear its reset flag after a chosen number of polls, or never. It then sweeps every stuck pattern over every port count of a four-slot configuration. Directed runs add slow-clearing ports, which force several passes and gaps, and a requested mask that leaves out a stuck port, which must end polling early while that port is still recovered.

// File: rtl/prs_pkg.sv
package prs_pkg;
   localparam int unsigned PHY_AW   = 5;
   localparam int unsigned REG_AW   = 5;
   localparam int unsigned DATA_W   = 16;
   localparam logic [REG_AW-1:0] CTRL_REG = '0;
   localparam int unsigned RST_BIT  = 15;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ARM_RD,
      ST_ARM_WR,
      ST_POLL_RD,
      ST_POLL_EVAL,
      ST_GAP,
      ST_FIX_CHK,
      ST_FIX_RD,
      ST_FIX_WR,
      ST_SETTLE,
      ST_REPORT
   } seq_state_e;
endpackage

// File: rtl/prs_ms_timer.sv
module prs_ms_timer #(
   parameter int unsigned LIMIT = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic reached
);
   localparam int unsigned W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q < LIM)) begin
         cnt_q <= cnt_q + W'(1);
      end
   end

   assign reached = (cnt_q >= LIM);
endmodule

// File: rtl/prs_addr_mux.sv
module prs_addr_mux #(
   parameter int unsigned PORTS = 8,
   parameter int unsigned IW    = 4,
   parameter int unsigned AW    = 5
) (
   input  logic [PORTS*AW-1:0] tbl_i,
   input  logic [IW-1:0]       idx_i,
   output logic [AW-1:0]       addr_o
);
   logic [AW-1:0] entry [PORTS];

   for (genvar g = 0; g < PORTS; g++) begin : g_entry
      assign entry[g] = tbl_i[g*AW +: AW];
   end

   always_comb begin
      addr_o = '0;
      for (int k = 0; k < PORTS; k++) begin
         if (idx_i == IW'(k)) addr_o = entry[k];
      end
   end
endmodule

// File: rtl/prs_req_port.sv
module prs_req_port #(
   parameter int unsigned AW         = 5,
   parameter int unsigned RW         = 5,
   parameter int unsigned DW         = 16,
   parameter bit          CLEAR_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          iss_wr,
   input  logic [AW-1:0] iss_phy,
   input  logic [RW-1:0] iss_reg,
   input  logic [DW-1:0] iss_data,
   output logic          req_valid,
   output logic          req_write,
   output logic [AW-1:0] req_phy,
   output logic [RW-1:0] req_reg,
   output logic [DW-1:0] req_wdata,
   input  logic          rsp_done,
   output logic          fin
);
   logic          vld_q;
   logic          wr_q;
   logic [AW-1:0] phy_q;
   logic [RW-1:0] reg_q;
   logic [DW-1:0] dat_q;

   assign fin = vld_q && rsp_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         wr_q  <= 1'b0;
         phy_q <= '0;
         reg_q <= '0;
         dat_q <= '0;
      end else if (fin) begin
         vld_q <= 1'b0;
      end else if (!vld_q && issue) begin
         vld_q <= 1'b1;
         wr_q  <= iss_wr;
         phy_q <= iss_phy;
         reg_q <= iss_reg;
         dat_q <= iss_data;
      end
   end

   assign req_valid = vld_q;

   if (CLEAR_IDLE) begin : g_masked
      assign req_write = vld_q & wr_q;
      assign req_phy   = vld_q ? phy_q : '0;
      assign req_reg   = vld_q ? reg_q : '0;
      assign req_wdata = vld_q ? dat_q : '0;
   end else begin : g_raw
      assign req_write = wr_q;
      assign req_phy   = phy_q;
      assign req_reg   = reg_q;
      assign req_wdata = dat_q;
   end
endmodule

// File: rtl/port_reset_seq.sv
module port_reset_seq
   import prs_pkg::*;
#(
   parameter int unsigned MAX_PORTS  = 8,
   parameter int unsigned TIMEOUT_MS = 1000,
   parameter int unsigned GAP_MS     = 50,
   parameter bit          CLEAR_IDLE = 1'b1,
   localparam int unsigned CW = $clog2(MAX_PORTS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       tick_ms,
   input  logic                       start,
   input  logic [CW-1:0]              port_count,
   input  logic [MAX_PORTS-1:0]       port_mask,
   input  logic [MAX_PORTS*PHY_AW-1:0] addr_table,
   output logic                       req_valid,
   output logic                       req_write,
   output logic [PHY_AW-1:0]          req_phy,
   output logic [REG_AW-1:0]          req_reg,
   output logic [DATA_W-1:0]          req_wdata,
   input  logic                       rsp_done,
   input  logic [DATA_W-1:0]          rsp_rdata,
   output logic                       busy,
   output logic                       done_pulse,
   output logic [MAX_PORTS-1:0]       done_mask
);
   localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PORTS);
   localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RST_BIT;

   if (MAX_PORTS < 1 || MAX_PORTS > 32) begin : g_bad_ports
      $error("MAX_PORTS must lie in 1..32");
   end
   if (GAP_MS < 1) begin : g_bad_gap
      $error("GAP_MS must be at least 1");
   end
   if (TIMEOUT_MS < 1) begin : g_bad_tmo
      $error("TIMEOUT_MS must be at least 1");
   end

   seq_state_e                   state_q;
   logic [CW-1:0]                idx_q;
   logic [CW-1:0]                cnt_q;
   logic [MAX_PORTS-1:0]         mask_q;
   logic [MAX_PORTS*PHY_AW-1:0]  tbl_q;
   logic [MAX_PORTS-1:0]         found_q;
   logic [MAX_PORTS-1:0]         result_q;
   logic [DATA_W-1:0]            rd_q;
   logic                         launched_q;

   logic                         in_range;
   logic [MAX_PORTS-1:0]         idx_oh;
   logic                         idx_found;
   logic [PHY_AW-1:0]            cur_phy;
   logic                         issue;
   logic                         iss_wr;
   logic [DATA_W-1:0]            iss_data;
   logic                         fin;
   logic                         gap_clr;
   logic                         gap_hit;
   logic                         tmo_clr;
   logic                         tmo_hit;

   assign in_range = (idx_q < cnt_q);

   always_comb begin
      idx_oh = '0;
      for (int k = 0; k < MAX_PORTS; k++) begin
         if (in_range && (idx_q == CW'(k))) idx_oh[k] = 1'b1;
      end
   end

   assign idx_found = |(found_q & idx_oh);

   prs_addr_mux #(
      .PORTS (MAX_PORTS),
      .IW    (CW),
      .AW    (PHY_AW)
   ) u_addr_mux (
      .tbl_i  (tbl_q),
      .idx_i  (idx_q),
      .addr_o (cur_phy)
   );

   assign gap_clr = !((state_q == ST_GAP) || (state_q == ST_SETTLE));
   assign tmo_clr = (state_q == ST_IDLE) || (state_q == ST_ARM_RD) ||
                    (state_q == ST_ARM_WR);

   prs_ms_timer #(.LIMIT(GAP_MS)) u_gap_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (gap_clr),
      .tick    (tick_ms),
      .reached (gap_hit)
   );

   prs_ms_timer #(.LIMIT(TIMEOUT_MS)) u_tmo_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmo_clr),
      .tick    (tick_ms),
      .reached (tmo_hit)
   );

   always_comb begin
      issue    = 1'b0;
      iss_wr   = 1'b0;
      iss_data = '0;
      unique case (state_q)
         ST_ARM_RD, ST_POLL_RD: begin
            issue = !launched_q && in_range;
         end
         ST_FIX_RD: begin
            issue = !launched_q;
         end
         ST_ARM_WR: begin
            issue    = !launched_q;
            iss_wr   = 1'b1;
            iss_data = rd_q | RST_MASK;
         end
         ST_FIX_WR: begin
            issue    = !launched_q;
            iss_wr   = 1'b1;
            iss_data = rd_q & ~RST_MASK;
         end
         default: ;
      endcase
   end

   prs_req_port #(
      .AW         (PHY_AW),
      .RW         (REG_AW),
      .DW         (DATA_W),
      .CLEAR_IDLE (CLEAR_IDLE)
   ) u_req_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .iss_wr    (iss_wr),
      .iss_phy   (cur_phy),
      .iss_reg   (CTRL_REG),
      .iss_data  (iss_data),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_phy   (req_phy),
      .req_reg   (req_reg),
      .req_wdata (req_wdata),
      .rsp_done  (rsp_done),
      .fin       (fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         cnt_q      <= '0;
         mask_q     <= '0;
         tbl_q      <= '0;
         found_q    <= '0;
         result_q   <= '0;
         rd_q       <= '0;
         launched_q <= 1'b0;
      end else begin
         if (issue) launched_q <= 1'b1;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  cnt_q   <= (port_count > CNT_MAX) ? CNT_MAX : port_count;
                  mask_q  <= port_mask;
                  tbl_q   <= addr_table;
                  found_q <= '0;
                  idx_q   <= '0;
                  state_q <= ST_ARM_RD;
               end
            end
            ST_ARM_RD: begin
               if (!in_range) begin
                  idx_q   <= '0;
                  state_q <= ST_POLL_RD;
               end else if (fin) begin
                  rd_q       <= rsp_rdata;
                  launched_q <= 1'b0;
                  state_q    <= ST_ARM_WR;
               end
            end
            ST_ARM_WR: begin
               if (fin) begin
                  launched_q <= 1'b0;
                  idx_q      <= idx_q + CW'(1);
                  state_q    <= ST_ARM_RD;
               end
            end
            ST_POLL_RD: begin
               if (!in_range) begin
                  state_q <= ST_POLL_EVAL;
               end else if (fin) begin
                  if (!rsp_rdata[RST_BIT]) found_q <= found_q | idx_oh;
                  launched_q <= 1'b0;
                  idx_q      <= idx_q + CW'(1);
               end
            end
            ST_POLL_EVAL: begin
               idx_q <= '0;
               if ((found_q == mask_q) || tmo_hit) state_q <= ST_FIX_CHK;
               else                                state_q <= ST_GAP;
            end
            ST_GAP: begin
               if (gap_hit) begin
                  idx_q   <= '0;
                  state_q <= ST_POLL_RD;
               end
            end
            ST_FIX_CHK: begin
               if (!in_range)      state_q <= ST_SETTLE;
               else if (idx_found) idx_q   <= idx_q + CW'(1);
               else                state_q <= ST_FIX_RD;
            end
            ST_FIX_RD: begin
               if (fin) begin
                  rd_q       <= rsp_rdata;
                  launched_q <= 1'b0;
                  state_q    <= ST_FIX_WR;
               end
            end
            ST_FIX_WR: begin
               if (fin) begin
                  launched_q <= 1'b0;
                  idx_q      <= idx_q + CW'(1);
                  state_q    <= ST_FIX_CHK;
               end
            end
            ST_SETTLE: begin
               if (gap_hit) begin
                  result_q <= found_q;
                  state_q  <= ST_REPORT;
               end
            end
            ST_REPORT: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done_pulse = (state_q == ST_REPORT);
   assign done_mask  = result_q;
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
   parameter int unsigned MAX_PORTS = 8,
   parameter int unsigned CW        = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 busy,
   input logic                 req_valid,
   input logic                 req_write,
   input logic [4:0]           req_phy,
   input logic [4:0]           req_reg,
   input logic [15:0]          req_wdata,
   input logic                 rsp_done,
   input logic                 done_pulse,
   input logic [MAX_PORTS-1:0] done_mask,
   input logic [CW-1:0]        cnt_q
);
   logic [MAX_PORTS-1:0] live;
   always_comb begin
      for (int k = 0; k < MAX_PORTS; k++) live[k] = (CW'(k) < cnt_q);
   end

   AST_REG_IS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_reg == 5'd0)); // R3
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_done) |=> (req_valid && $stable(req_write) &&
         $stable(req_phy) && $stable(req_wdata))); // R3
   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && rsp_done) |=> !req_valid); // R3
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> (!done_pulse && !busy)); // R9
   AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_pulse |-> $stable(done_mask)); // R9
   AST_MASK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> ((done_mask & ~live) == '0)); // R10
endmodule

bind port_reset_seq prs_checker #(
   .MAX_PORTS (MAX_PORTS),
   .CW        (CW)
) u_prs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_phy    (req_phy),
   .req_reg    (req_reg),
   .req_wdata  (req_wdata),
   .rsp_done   (rsp_done),
   .done_pulse (done_pulse),
   .done_mask  (done_mask),
   .cnt_q      (cnt_q)
);

// File: tb/port_reset_seq_bench.sv
`timescale 1ns/1ps
module port_reset_seq_bench;
   localparam int MAXP = 4;
   localparam int TMO  = 6;
   localparam int GAP  = 2;
   localparam int TICK = 40;
   localparam int CW   = $clog2(MAXP + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_ms = 1'b0;
   logic              start = 1'b0;
   logic [CW-1:0]     port_count = '0;
   logic [MAXP-1:0]   port_mask = '0;
   logic [MAXP*5-1:0] addr_table = '0;
   logic              req_valid, req_write;
   logic [4:0]        req_phy, req_reg;
   logic [15:0]       req_wdata;
   logic              rsp_done = 1'b0;
   logic [15:0]       rsp_rdata = '0;
   logic              busy, done_pulse;
   logic [MAXP-1:0]   done_mask;

   always #2 clk = ~clk;

   port_reset_seq #(
      .MAX_PORTS  (MAXP),
      .TIMEOUT_MS (TMO),
      .GAP_MS     (GAP)
   ) u_port_reset_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_ms    (tick_ms),
      .start      (start),
      .port_count (port_count),
      .port_mask  (port_mask),
      .addr_table (addr_table),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_phy    (req_phy),
      .req_reg    (req_reg),
      .req_wdata  (req_wdata),
      .rsp_done   (rsp_done),
      .rsp_rdata  (rsp_rdata),
      .busy       (busy),
      .done_pulse (done_pulse),
      .done_mask  (done_mask)
   );

   int n_chk = 0;
   int n_fail = 0;
   int tick_total = 0;
   int bad_reg = 0;
   int wait_c = 0;

   logic [15:0] reg0 [32];
   int          lat [32];
   bit          stuck [32];
   int          pcnt [32];
   int          nrd [32];
   int          nwr [32];
   logic [15:0] wr_first [32];
   int          lat_cfg [MAXP];

   function automatic logic [15:0] base_val(input int a);
      return (16'h3100 | 16'(a) | 16'(a << 6)) & 16'h7fff;
   endfunction

   initial begin
      forever begin
         repeat (TICK) @(negedge clk);
         tick_ms = 1'b1;
         @(negedge clk);
         tick_ms = 1'b0;
      end
   end

   always @(posedge clk) if (tick_ms) tick_total <= tick_total + 1;

   // behavioural PHY responder
   always @(posedge clk) begin
      if (!rst_n) begin
         rsp_done <= 1'b0;
         wait_c   = 0;
      end else if (rsp_done) begin
         rsp_done <= 1'b0;
         wait_c   = 0;
      end else if (req_valid) begin
         if (wait_c < 2) begin
            wait_c = wait_c + 1;
         end else begin
            int a;
            a = int'(req_phy);
            if (req_reg != 5'd0) bad_reg = bad_reg + 1;
            if (req_write) begin
               nwr[a] = nwr[a] + 1;
               if (nwr[a] == 1) wr_first[a] = req_wdata;
               reg0[a] = req_wdata;
               pcnt[a] = 0;
            end else begin
               nrd[a] = nrd[a] + 1;
               if (reg0[a][15] && !stuck[a]) begin
                  pcnt[a] = pcnt[a] + 1;
                  if (pcnt[a] >= lat[a]) reg0[a][15] = 1'b0;
               end
               rsp_rdata <= reg0[a];
            end
            rsp_done <= 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input string what, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d..%0d", tag, what, act, lo, hi);
      end
   endtask

   function automatic int slot_addr(input int seed, input int i);
      return (seed * 5 + i * 9 + 3) & 31;
   endfunction

   task automatic run_case(input int cnt, input logic [MAXP-1:0] msk,
                           input logic [MAXP-1:0] stk, input int seed, input bit poke);
      logic [MAXP-1:0] exp_found;
      int passes, t0, t1, cyc, extra;
      bit fast, got;
      for (int a = 0; a < 32; a++) begin
         reg0[a] = base_val(a); lat[a] = 1; stuck[a] = 1'b0;
         pcnt[a] = 0; nrd[a] = 0; nwr[a] = 0; wr_first[a] = '0;
      end
      exp_found = '0;
      passes = 1;
      for (int i = 0; i < MAXP; i++) begin
         addr_table[i*5 +: 5] = 5'(slot_addr(seed, i));
         lat[slot_addr(seed, i)]   = lat_cfg[i];
         stuck[slot_addr(seed, i)] = stk[i];
         if (i < cnt && !stk[i]) exp_found[i] = 1'b1;
         if (i < cnt && msk[i] && lat_cfg[i] > passes) passes = lat_cfg[i];
      end
      fast = (exp_found == msk);
      port_count = CW'(cnt);
      port_mask  = msk;
      @(negedge clk);
      start = 1'b1;
      t0 = tick_total;
      @(negedge clk);
      start = 1'b0;
      got = 1'b0;
      cyc = 0;
      while (!got && cyc < 20000) begin
         if (poke && cyc == 60) begin
            port_count = CW'(MAXP); port_mask = '1; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
         if (done_pulse) got = 1'b1;
      end
      start = 1'b0;
      t1 = tick_total;
      chk("R9", "done pulse seen", int'(got), 1);
      chk("R5", "completion mask", int'(done_mask), int'(exp_found));
      if (fast) chk_rng("R6", "ticks early stop", t1 - t0, passes * GAP, passes * GAP + 3);
      else      chk_rng("R6", "ticks timeout", t1 - t0, TMO + GAP, TMO + 2 * GAP + 3);
      for (int i = 0; i < MAXP; i++) begin
         int a;
         a = slot_addr(seed, i);
         if (i < cnt) begin
            chk("R11", "slot accessed", int'(nwr[a] > 0), 1);
            chk("R4", "reset write keeps bits", int'(wr_first[a]), int'(base_val(a) | 16'h8000));
            chk("R8", "final reg0", int'(reg0[a]), int'(base_val(a)));
            chk("R8", "write count", nwr[a], exp_found[i] ? 1 : 2);
            if (fast) chk("R5", "reads per slot", nrd[a], 1 + passes + (exp_found[i] ? 0 : 1));
            else      chk_rng("R7", "reads while stuck", nrd[a], 4, 20);
         end else begin
            chk("R10", "idle slot untouched", nrd[a] + nwr[a], 0);
         end
      end
      @(negedge clk);
      chk("R9", "pulse one cycle", int'(done_pulse), 0);
      chk("R2", "idle after run", int'(busy), 0);
      chk("R3", "register number", bad_reg, 0);
      if (poke) begin
         extra = 0;
         for (int k = 0; k < 150; k++) begin
            @(negedge clk);
            if (done_pulse || busy) extra++;
         end
         chk("R2", "no run from busy start", extra, 0);
         chk("R9", "mask held", int'(done_mask), int'(exp_found));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < MAXP; i++) lat_cfg[i] = 1;
      repeat (5) @(negedge clk);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "req_valid", int'(req_valid), 0);
      chk("R1", "done_pulse", int'(done_pulse), 0);
      chk("R1", "done_mask", int'(done_mask), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "idle after release", int'(busy), 0);

      // sweep every port count against every stuck pattern
      for (int c = 0; c <= MAXP; c++) begin
         for (int s = 0; s < 16; s++) begin
            run_case(c, MAXP'((1 << c) - 1), MAXP'(s), c * 16 + s, 1'b0);
         end
      end

      // slow-clearing ports force several passes (R5, R7)
      lat_cfg[0] = 1; lat_cfg[1] = 3; lat_cfg[2] = 2; lat_cfg[3] = 1;
      run_case(4, 4'hf, 4'h0, 7, 1'b0);
      for (int i = 0; i < MAXP; i++) lat_cfg[i] = 1;

      // requested mask leaves out a stuck port (R6, R8)
      run_case(3, 4'b0011, 4'b0100, 11, 1'b0);

      // start while busy is ignored (R2)
      run_case(2, 4'b0011, 4'b0001, 21, 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule